// File: doc/BRIEF.md
# Switch Wake-up and Event Latch

This block supervises two active-low switch inputs and the shared single-wire host line for a low-frequency field transmitter. While the device sleeps, a debounced low on either switch wakes it. The block then pulls the single-wire line low for a fixed number of cycles to alert the host, and that same low pulse is also the start bit of the first command. A debounced low driven onto the line by the host wakes the device as well, but without any pulse.

Once the device is awake, every debounced low on a switch is held in a per-input event flag. The flag stays set until the protocol engine reports that the switch status response has been shifted out, or until the device is sent back to sleep. The block also holds one pull-up disable bit per switch input. It raises a one-cycle field start strobe when wake-up is confirmed and the auto-field option is set.

All pins are plain control and status signals. No data stream passes through the block, so no port has a valid/ready handshake or back-pressure. No output depends combinationally on any input.

Top module: `swl_switch_wake`

## Requirements
- R1: During and right after reset the block is asleep (`awake_o`=0). It does not pull the line low. `field_start_o` is 0 and `pullup_off_o` is all zeros. `sw_status_o` reads 4'b0011, meaning both switches read high and no event is held.
- R2: Each switch input passes through a two-flop synchronizer. A synchronized low held for `SW_DEB_CYC` consecutive cycles completes the switch debounce. A return to high before that point restarts the count from zero.
- R3: A switch debounce that completes while asleep wakes the device. `awake_o` rises, and in the same cycle `line_pull_low_o` goes to 1 for exactly `PULSE_CYC` cycles.
- R4: While asleep, a synchronized low on `line_i` held for `LINE_DEB_CYC` consecutive cycles wakes the device with no pulse. A shorter low does not wake it, and lows on `line_i` have no effect while awake.
- R5: A completed switch debounce sets that input's event flag. `sw_status_o[0]` reports SW1 and `sw_status_o[1]` reports SW2, each reading 0 while its flag is set and 1 otherwise. `sw_status_o[3:2]` always read 0.
- R6: `status_rd_i` while awake clears all event flags. If a debounce completes in the same cycle, that input's flag stays set.
- R7: `sleep_req_i` while awake returns the block to sleep and clears every event flag, and this clear overrides a debounce that completes in the same cycle.
- R8: `cfg_we_i` loads `cfg_pu_dis_i` into `pullup_off_o` on the next edge. Bit i = 1 turns off the pull-up of switch i. The value is kept across sleep.
- R9: `field_start_o` pulses for one cycle only when wake-up is confirmed and `auto_field_i` was 1 in the confirming cycle. For a switch wake, the confirming cycle is the last pulse cycle. For a host wake, it is the cycle in which the line debounce completes.
- R10: If a switch debounce and a line debounce complete in the same sleeping cycle, the switch wake wins and the pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_n_i | input | NUM_SW | Raw switch levels, low means pressed |
| line_i | input | 1 | Sampled level of the single-wire line |
| status_rd_i | input | 1 | Strobe: the switch status response has been sent |
| sleep_req_i | input | 1 | Strobe: enter sleep (timeout or standby command) |
| cfg_we_i | input | 1 | Write strobe for the pull-up disable bits |
| cfg_pu_dis_i | input | NUM_SW | New pull-up disable bits |
| auto_field_i | input | 1 | Auto-field option: start the carrier on wake-up |
| awake_o | output | 1 | Device is awake (this includes the wake pulse) |
| line_pull_low_o | output | 1 | Pull the single-wire line low (wake pulse / first start bit) |
| field_start_o | output | 1 | One-cycle strobe that starts the carrier |
| pullup_off_o | output | NUM_SW | Per-input pull-up disable |
| sw_status_o | output | 4 | Switch status response bits |

## Verification
Two collisions are provoked on purpose. In the first, a status read strobe is issued while a switch is held low, so a flag set and a read clear fall in the same cycle; the check is that the flag still reads as a latched event afterwards. In the second, the line and a switch are dropped low with their start times offset by the difference of the two debounce lengths, so both debounces complete in one sleeping cycle; the check is that the wake pulse appears. In both cases a behavioural model in the bench decides the winner from the requirements and compares every output on every cycle.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [1:0] {
    WK_SLEEP = 2'd0,
    WK_PULSE = 2'd1,
    WK_AWAKE = 2'd2
  } wake_st_t;

  localparam int STATUS_W = 4;
endpackage

// File: rtl/swl_sync2.sv
module swl_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  // idle level of every watched line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q_o    <= '1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/swl_lowdeb.sv
module swl_lowdeb #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lvl_i,
  output logic low_ok_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC);

  logic [CW-1:0] cnt_q;

  // counts consecutive low cycles, saturates at the limit, restarts on high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || lvl_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low_ok_o = en_i && (cnt_q == LIM);
endmodule

// File: rtl/swl_wake_fsm.sv
module swl_wake_fsm
  import swl_pkg::*;
#(
  parameter int PULSE_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_hit_i,
  input  logic line_hit_i,
  input  logic sleep_req_i,
  input  logic auto_field_i,
  output logic in_sleep_o,
  output logic awake_o,
  output logic pull_low_o,
  output logic field_start_o
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PULSE_CYC - 1);

  wake_st_t st_q;
  logic [PW-1:0] pcnt_q;
  logic fstart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WK_SLEEP;
      pcnt_q   <= '0;
      fstart_q <= 1'b0;
    end else begin
      fstart_q <= 1'b0;
      case (st_q)
        WK_SLEEP: begin
          pcnt_q <= '0;
          if (sw_hit_i) begin
            st_q <= WK_PULSE;          // switch wake has priority
          end else if (line_hit_i) begin
            st_q     <= WK_AWAKE;
            fstart_q <= auto_field_i;
          end
        end
        WK_PULSE: begin
          if (sleep_req_i) begin
            st_q <= WK_SLEEP;
          end else if (pcnt_q == PLAST) begin
            st_q     <= WK_AWAKE;
            fstart_q <= auto_field_i;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        WK_AWAKE: begin
          if (sleep_req_i) st_q <= WK_SLEEP;
        end
        default: st_q <= WK_SLEEP;
      endcase
    end
  end

  assign in_sleep_o    = (st_q == WK_SLEEP);
  assign awake_o       = (st_q != WK_SLEEP);
  assign pull_low_o    = (st_q == WK_PULSE);
  assign field_start_o = fstart_q;
endmodule

// File: rtl/swl_evt_bank.sv
module swl_evt_bank #(
  parameter int NUM_SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] hit_i,
  input  logic              awake_i,
  input  logic              rd_i,
  input  logic              sleep_i,
  output logic [NUM_SW-1:0] evt_o
);
  for (genvar g = 0; g < NUM_SW; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_o[g] <= 1'b0;
      end else if (sleep_i && awake_i) begin
        evt_o[g] <= 1'b0;              // sleep clear beats a new event
      end else if (hit_i[g]) begin
        evt_o[g] <= 1'b1;              // new event beats a read clear
      end else if (rd_i && awake_i) begin
        evt_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swl_switch_wake.sv
module swl_switch_wake
  import swl_pkg::*;
#(
  parameter int NUM_SW       = 2,
  parameter int SW_DEB_CYC   = 250000,
  parameter int LINE_DEB_CYC = 1250,
  parameter int PULSE_CYC    = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] sw_n_i,
  input  logic              line_i,
  input  logic              status_rd_i,
  input  logic              sleep_req_i,
  input  logic              cfg_we_i,
  input  logic [NUM_SW-1:0] cfg_pu_dis_i,
  input  logic              auto_field_i,
  output logic              awake_o,
  output logic              line_pull_low_o,
  output logic              field_start_o,
  output logic [NUM_SW-1:0] pullup_off_o,
  output logic [3:0]        sw_status_o
);
  logic [NUM_SW-1:0] sw_s;
  logic              line_s;
  logic [NUM_SW-1:0] sw_ok;
  logic              line_ok;
  logic              in_sleep;
  logic [NUM_SW-1:0] evt;

  swl_sync2 #(.W(NUM_SW + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({line_i, sw_n_i}),
    .q_o   ({line_s, sw_s})
  );

  for (genvar g = 0; g < NUM_SW; g++) begin : g_swdeb
    swl_lowdeb #(.CYC(SW_DEB_CYC)) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (1'b1),
      .lvl_i    (sw_s[g]),
      .low_ok_o (sw_ok[g])
    );
  end

  swl_lowdeb #(.CYC(LINE_DEB_CYC)) u_line_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (in_sleep),
    .lvl_i    (line_s),
    .low_ok_o (line_ok)
  );

  swl_wake_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_hit_i      (|sw_ok),
    .line_hit_i    (line_ok),
    .sleep_req_i   (sleep_req_i),
    .auto_field_i  (auto_field_i),
    .in_sleep_o    (in_sleep),
    .awake_o       (awake_o),
    .pull_low_o    (line_pull_low_o),
    .field_start_o (field_start_o)
  );

  swl_evt_bank #(.NUM_SW(NUM_SW)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (sw_ok),
    .awake_i (awake_o),
    .rd_i    (status_rd_i),
    .sleep_i (sleep_req_i),
    .evt_o   (evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pullup_off_o <= '0;
    else if (cfg_we_i) pullup_off_o <= cfg_pu_dis_i;
  end

  for (genvar b = 0; b < STATUS_W; b++) begin : g_stat
    if (b < NUM_SW) begin : g_used
      assign sw_status_o[b] = ~evt[b];
    end else begin : g_spare
      assign sw_status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/swl_switch_wake_chk.sv
module swl_switch_wake_chk #(
  parameter int NUM_SW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req_i,
  input logic              cfg_we_i,
  input logic [NUM_SW-1:0] cfg_pu_dis_i,
  input logic              awake_o,
  input logic              line_pull_low_o,
  input logic              field_start_o,
  input logic [NUM_SW-1:0] pullup_off_o,
  input logic [3:0]        sw_status_o
);
  assert_pulse_when_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low_o |-> awake_o);

  assert_pulse_starts_at_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_low_o) |-> $rose(awake_o));

  assert_sleep_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req_i && awake_o) |=> (!awake_o && (sw_status_o[NUM_SW-1:0] == {NUM_SW{1'b1}})));

  assert_sleep_only_on_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(awake_o) |-> $past(sleep_req_i));

  assert_pullup_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (pullup_off_o == $past(cfg_pu_dis_i)));

  assert_field_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_o |=> !field_start_o);

  assert_field_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_o |-> (awake_o && !line_pull_low_o));
endmodule

bind swl_switch_wake swl_switch_wake_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sleep_req_i     (sleep_req_i),
  .cfg_we_i        (cfg_we_i),
  .cfg_pu_dis_i    (cfg_pu_dis_i),
  .awake_o         (awake_o),
  .line_pull_low_o (line_pull_low_o),
  .field_start_o   (field_start_o),
  .pullup_off_o    (pullup_off_o),
  .sw_status_o     (sw_status_o)
);

// File: tb/sim_swl_switch_wake.sv
`timescale 1ns/1ps
module sim_swl_switch_wake;
  localparam int NSW = 2;
  localparam int SWD = 8;
  localparam int LND = 6;
  localparam int PLS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSW-1:0] sw_n = '1;
  logic line = 1'b1;
  logic status_rd = 1'b0;
  logic sleep_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [NSW-1:0] cfg_wd = '0;
  logic auto_field = 1'b0;
  logic awake, pull_low, fstart;
  logic [NSW-1:0] pu_off;
  logic [3:0] stat;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  swl_switch_wake #(.NUM_SW(NSW), .SW_DEB_CYC(SWD), .LINE_DEB_CYC(LND), .PULSE_CYC(PLS)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_n_i(sw_n), .line_i(line), .status_rd_i(status_rd),
    .sleep_req_i(sleep_req), .cfg_we_i(cfg_we), .cfg_pu_dis_i(cfg_wd),
    .auto_field_i(auto_field), .awake_o(awake), .line_pull_low_o(pull_low),
    .field_start_o(fstart), .pullup_off_o(pu_off), .sw_status_o(stat));

  // behavioural reference: 0 asleep, 1 pulsing, 2 awake
  int m_mode = 0;
  int m_pc = 0;
  int m_swlow[NSW];
  int m_lnlow = 0;
  logic [NSW-1:0] m_sa = '1, m_sb = '1;
  logic m_la = 1'b1, m_lb = 1'b1;
  logic [NSW-1:0] m_ev = '0;
  logic [NSW-1:0] m_pu = '0;
  logic m_fs = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pc = 0; m_lnlow = 0; m_sa = '1; m_sb = '1; m_la = 1; m_lb = 1;
      m_ev = '0; m_pu = '0; m_fs = 0;
      for (int i = 0; i < NSW; i++) m_swlow[i] = 0;
    end else begin
      logic [NSW-1:0] hit;
      logic lhit, up;
      int nmode;
      up = (m_mode != 0);
      for (int i = 0; i < NSW; i++) hit[i] = (m_swlow[i] == SWD);
      lhit = (m_mode == 0) && (m_lnlow == LND);
      for (int i = 0; i < NSW; i++) begin
        if (sleep_req && up) m_ev[i] = 0;
        else if (hit[i]) m_ev[i] = 1;
        else if (status_rd && up) m_ev[i] = 0;
      end
      m_fs = 0;
      nmode = m_mode;
      if (m_mode == 0) begin
        m_pc = 0;
        if (hit != 0) nmode = 1;
        else if (lhit) begin nmode = 2; m_fs = auto_field; end
      end else if (m_mode == 1) begin
        if (sleep_req) nmode = 0;
        else if (m_pc == PLS - 1) begin nmode = 2; m_fs = auto_field; end
        else m_pc++;
      end else if (sleep_req) nmode = 0;
      for (int i = 0; i < NSW; i++)
        m_swlow[i] = m_sb[i] ? 0 : ((m_swlow[i] < SWD) ? m_swlow[i] + 1 : SWD);
      if (m_mode != 0 || m_lb) m_lnlow = 0;
      else if (m_lnlow < LND) m_lnlow++;
      m_mode = nmode;
      m_sb = m_sa; m_sa = sw_n;
      m_lb = m_la; m_la = line;
      if (cfg_we) m_pu = cfg_wd;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [3:0] es;
      es = 4'b0000;
      for (int i = 0; i < NSW; i++) es[i] = ~m_ev[i];
      chk(awake === (m_mode != 0), "R2/R4 awake", awake, m_mode != 0);
      chk(pull_low === (m_mode == 1), "R3/R10 pull_low", pull_low, m_mode == 1);
      chk(stat === es, "R5/R6/R7 status", stat, es);
      chk(pu_off === m_pu, "R8 pullup_off", pu_off, m_pu);
      chk(fstart === m_fs, "R9 field_start", fstart, m_fs);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; tick(1); sleep_req = 0; tick(2);
  endtask

  initial begin
    int plen;
    tick(3);
    // R1 reset state
    chk(awake === 0 && pull_low === 0 && fstart === 0, "R1 reset ctrl", {awake, pull_low, fstart}, 0);
    chk(stat === 4'b0011, "R1 reset status", stat, 4'b0011);
    chk(pu_off === 2'b00, "R1 reset pullup", pu_off, 0);
    rst_n = 1; tick(2);

    // R2 bounce restarts the debounce, then a solid press wakes with a pulse
    sw_n[0] = 0; tick(SWD - 3); sw_n[0] = 1; tick(2);
    chk(awake === 0, "R2 bounce no wake", awake, 0);
    sw_n[0] = 0;
    plen = 0;
    while (!awake && plen < 100) begin tick(1); plen++; end
    chk(awake === 1, "R2 press wakes", awake, 1);
    plen = 0;
    while (pull_low && plen < 100) begin tick(1); plen++; end
    chk(plen == PLS, "R3 pulse length", plen, PLS);
    sw_n[0] = 1; tick(4);
    chk(stat === 4'b0010, "R5 SW1 latched", stat, 4'b0010);

    // R6 read clears
    status_rd = 1; tick(1); status_rd = 0; tick(1);
    chk(stat === 4'b0011, "R6 read clears", stat, 4'b0011);

    // R5 SW2 while awake; R4 line low while awake is ignored
    line = 0; sw_n[1] = 0; tick(SWD + 4); sw_n[1] = 1; line = 1; tick(3);
    chk(stat === 4'b0001, "R5 SW2 latched", stat, 4'b0001);
    chk(pull_low === 0, "R4 line ignored awake", pull_low, 0);

    // R6 read with switch still held: set wins
    sw_n[1] = 0; tick(SWD + 4);
    status_rd = 1; tick(1); status_rd = 0; tick(1);
    chk(stat[1] === 0, "R6 set beats clear", stat[1], 0);
    sw_n[1] = 1; tick(3);
    status_rd = 1; tick(1); status_rd = 0; tick(1);

    // R8 pull-up disable write, kept through sleep
    cfg_wd = 2'b10; cfg_we = 1; tick(1); cfg_we = 0; tick(1);
    chk(pu_off === 2'b10, "R8 write", pu_off, 2'b10);
    pulse_sleep();
    chk(awake === 0, "R7 sleep", awake, 0);
    chk(pu_off === 2'b10, "R8 kept in sleep", pu_off, 2'b10);

    // R4 short line low then real host wake, R9 field start
    auto_field = 1;
    line = 0; tick(LND - 2); line = 1; tick(3);
    chk(awake === 0, "R4 short low ignored", awake, 0);
    line = 0; tick(LND + 5); line = 1; tick(2);
    chk(awake === 1 && pull_low === 0, "R4 host wake", {awake, pull_low}, 2);
    pulse_sleep();

    // R9 switch wake with auto field
    sw_n[1] = 0; tick(SWD + PLS + 6); sw_n[1] = 1; tick(3);
    chk(awake === 1, "R9 switch wake", awake, 1);
    // R7 sleep while switch held clears then re-wakes
    auto_field = 0;
    sw_n[0] = 0; tick(SWD + PLS + 4);
    pulse_sleep();
    sw_n[0] = 1; tick(PLS + 6);
    pulse_sleep();
    status_rd = 1; tick(1); status_rd = 0; pulse_sleep();

    // R10 simultaneous debounce completion: switch wins
    sw_n[1] = 0; tick(SWD - LND); line = 0;
    tick(LND + 3);
    chk(pull_low === 1, "R10 switch wins", pull_low, 1);
    tick(PLS + 2); sw_n[1] = 1; line = 1; tick(4);
    pulse_sleep();
    tick(3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule